// File: doc/BRIEF.md
# Indexed Configuration Port with SRAM Window

This block holds a small file of 16-bit configuration registers that a host reaches through two ports: an index port that selects a register and a data port that reads or writes the selected register. The host bus has a port select, a data word in, a data word out, single-cycle read and write strobes, and a byte/word size select. Read data is registered and appears on the output the cycle after the read strobe.

A mode input changes what the two lowest indices mean. In bus-master mode, indices 0 and 1 are 4-bit command strobe length fields with zero upper bits. In slave programmed-I/O mode, index 1 becomes a pointer into an internal byte-addressed SRAM, and index 0 becomes a window onto that SRAM. Each accepted window access advances the pointer by its own size. A byte access at an odd pointer is refused. The other registers only keep their reset values and their read/write rules.

Top module: `idxcfg_port`

## Requirements
- R1: A write to the index port (port select 0) stores the low 4 bits of the write data as the index. A read of the index port returns that index, zero-extended, on the output the cycle after the strobe.
- R2: After reset, in bus-master mode, data-port reads at indices 0 to 9 return 0x0005, 0x0005, 0x0002, 0x8000, 0x0000, 0x0084, 0x0008, 0x0090, 0x0000 and 0x0000.
- R3: Indices 2 to 7 and 9 are full 16-bit read/write registers. Any register read appears on the output one cycle after the read strobe.
- R4: Index 8 is read-only. Writes to it leave its value at 0x0000.
- R5: In bus-master mode (mode input 0), indices 0 and 1 store only write-data bits 3:0, and they read back with bits 15:4 at zero.
- R6: In programmed-I/O mode (mode input 1), index 1 is the SRAM pointer. Its reset value is 0. A write loads the low log2(SRAM size) bits, and a read returns them zero-extended. The pointer wraps modulo the SRAM size.
- R7: In programmed-I/O mode, a word access (size select 1) at index 0 writes or reads little-endian: bits 7:0 go to the pointer address and bits 15:8 to pointer+1, modulo the SRAM size. The pointer then advances by 2.
- R8: In programmed-I/O mode, a byte access (size select 0) at index 0 with an even pointer writes data bits 7:0, or reads the byte zero-extended. The pointer then advances by 1.
- R9: In programmed-I/O mode, a byte access at index 0 with an odd pointer is refused. The SRAM and the pointer are unchanged, and a refused read returns 0x0000.
- R10: An index from 10 to 15 reads as 0x0000 and ignores writes.
- R11: The strobe length fields at indices 0 and 1 keep their values across programmed-I/O mode activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pio_mode | input | 1 | 1 selects slave programmed-I/O mode, 0 selects bus-master mode |
| host_port | input | 1 | 0 selects the index port, 1 selects the data port |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_word | input | 1 | 1 selects a word access, 0 a low-byte access |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. They also assume the mode input is steady around a data-port access, because each pointer-step property compares the pointer against its value one cycle earlier. The stimulus keeps to both assumptions: every access is driven by a task that raises exactly one strobe for one cycle. The mode input changes only while the bus is idle. Before any SRAM byte is read, the stimulus writes it through the window, so no expected value relies on SRAM contents after reset.

// File: rtl/idxcfg_pkg.sv
package idxcfg_pkg;

    localparam int REG_W    = 16;
    localparam int NUM_REGS = 10;
    localparam int IDX_W    = 4;
    localparam int RO_IDX   = 8;

    typedef enum logic {
        PORT_INDEX = 1'b0,
        PORT_DATA  = 1'b1
    } port_sel_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic             rd;
        logic             wr;
        port_sel_e        port;
        acc_size_e        size;
        logic [REG_W-1:0] wdata;
    } host_req_t;

    // Value each register takes on reset.
    function automatic logic [REG_W-1:0] reg_reset(input int unsigned i);
        logic [REG_W-1:0] v;
        case (i)
            0, 1:    v = 16'h0005;
            2:       v = 16'h0002;
            3:       v = 16'h8000;
            5:       v = 16'h0084;
            6:       v = 16'h0008;
            7:       v = 16'h0090;
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

    // Bits a host write may change in each register.
    function automatic logic [REG_W-1:0] reg_wmask(input int unsigned i);
        logic [REG_W-1:0] m;
        case (i)
            0, 1:    m = 16'h000F;
            RO_IDX:  m = 16'h0000;
            default: m = 16'hFFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/idxcfg_regbank.sv
module idxcfg_regbank
    import idxcfg_pkg::*;
#(
    parameter int N_REGS = NUM_REGS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata
);

    logic [REG_W-1:0] rq [N_REGS];

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        localparam logic [REG_W-1:0] RST_V = reg_reset(i);
        localparam logic [REG_W-1:0] MASK  = reg_wmask(i);
        logic [REG_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RST_V;
            end else if (we && idx == IDX_W'(i)) begin
                q <= (q & ~MASK) | (wdata & MASK);
            end
        end

        assign rq[i] = q;
    end

    // Indices without a register fall through to zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (idx == IDX_W'(i)) rdata = rq[i];
        end
    end

endmodule

// File: rtl/idxcfg_sram.sv
module idxcfg_sram
    import idxcfg_pkg::*;
#(
    parameter int BYTES = 256,
    localparam int AW   = $clog2(BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_load,
    input  logic [AW-1:0]    ptr_wdata,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  acc_size_e        acc_size,
    input  logic [REG_W-1:0] wdata,
    output logic [AW-1:0]    ptr,
    output logic [REG_W-1:0] rdata
);

    logic [7:0]    mem [BYTES];
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_p1;
    logic [AW-1:0] step;

    assign ptr_p1 = ptr_q + AW'(1);
    assign step   = (acc_size == SZ_WORD) ? AW'(2) : AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= ptr_wdata;
        end else if (acc_en) begin
            ptr_q <= ptr_q + step;
        end
    end

    always_ff @(posedge clk) begin
        if (acc_en && acc_wr) begin
            mem[ptr_q] <= wdata[7:0];
            if (acc_size == SZ_WORD) mem[ptr_p1] <= wdata[15:8];
        end
    end

    assign rdata = (acc_size == SZ_WORD) ? {mem[ptr_p1], mem[ptr_q]}
                                         : {8'h00, mem[ptr_q]};
    assign ptr   = ptr_q;

endmodule

// File: rtl/idxcfg_port.sv
module idxcfg_port
    import idxcfg_pkg::*;
#(
    parameter int SRAM_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pio_mode,
    input  logic        host_port,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic        host_word,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata
);

    localparam int AW = $clog2(SRAM_BYTES);

    host_req_t        req;
    logic [IDX_W-1:0] idx_q;
    logic [REG_W-1:0] rdata_q;
    logic [REG_W-1:0] rd_next;
    logic [REG_W-1:0] bank_rdata;
    logic [REG_W-1:0] sram_rdata;
    logic [AW-1:0]    sram_ptr;
    logic             data_acc;
    logic             sel_sram;
    logic             sel_ptr;
    logic             odd_reject;
    logic             sram_acc;
    logic             ptr_load;
    logic             reg_we;

    assign req.rd    = host_rd;
    assign req.wr    = host_wr;
    assign req.port  = port_sel_e'(host_port);
    assign req.size  = acc_size_e'(host_word);
    assign req.wdata = host_wdata;

    // Decode of the selected target.
    assign data_acc   = (req.rd || req.wr) && req.port == PORT_DATA;
    assign sel_sram   = pio_mode && idx_q == IDX_W'(0);
    assign sel_ptr    = pio_mode && idx_q == IDX_W'(1);
    assign odd_reject = sel_sram && req.size == SZ_BYTE && sram_ptr[0];
    assign sram_acc   = data_acc && sel_sram && !odd_reject;
    assign ptr_load   = req.wr && req.port == PORT_DATA && sel_ptr;
    assign reg_we     = req.wr && req.port == PORT_DATA && !sel_sram && !sel_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (req.wr && req.port == PORT_INDEX) begin
            idx_q <= req.wdata[IDX_W-1:0];
        end
    end

    idxcfg_regbank #(
        .N_REGS(NUM_REGS)
    ) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (reg_we),
        .idx  (idx_q),
        .wdata(req.wdata),
        .rdata(bank_rdata)
    );

    idxcfg_sram #(
        .BYTES(SRAM_BYTES)
    ) u_sram (
        .clk      (clk),
        .rst      (rst),
        .ptr_load (ptr_load),
        .ptr_wdata(req.wdata[AW-1:0]),
        .acc_en   (sram_acc),
        .acc_wr   (req.wr),
        .acc_size (req.size),
        .wdata    (req.wdata),
        .ptr      (sram_ptr),
        .rdata    (sram_rdata)
    );

    always_comb begin
        if (req.port == PORT_INDEX) begin
            rd_next = REG_W'(idx_q);
        end else if (sel_sram) begin
            rd_next = odd_reject ? '0 : sram_rdata;
        end else if (sel_ptr) begin
            rd_next = REG_W'(sram_ptr);
        end else begin
            rd_next = bank_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.rd) begin
            rdata_q <= rd_next;
        end
    end

    assign host_rdata = rdata_q;

endmodule

// File: rtl/idxcfg_port_chk.sv
module idxcfg_port_chk #(
    parameter int SRAM_BYTES = 256,
    localparam int AW = $clog2(SRAM_BYTES)
) (
    input logic          clk,
    input logic          rst,
    input logic          pio_mode,
    input logic          host_port,
    input logic          host_rd,
    input logic          host_wr,
    input logic          host_word,
    input logic [15:0]   host_rdata,
    input logic [3:0]    idx_q,
    input logic [AW-1:0] ptr_q
);

    logic win_acc;
    assign win_acc = (host_rd || host_wr) && host_port && pio_mode && idx_q == 4'd0;

    // Input assumption: one strobe at a time (R1 access protocol).
    p_one_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        !(host_rd && host_wr));

    p_idx_read_r1: assert property (@(posedge clk) disable iff (rst)
        host_rd && !host_port |=> host_rdata == 16'($past(idx_q)));

    p_ro_zero_r4: assert property (@(posedge clk) disable iff (rst)
        host_rd && host_port && idx_q == 4'd8 |=> host_rdata == 16'h0000);

    p_master_upper_r5: assert property (@(posedge clk) disable iff (rst)
        host_rd && host_port && !pio_mode && idx_q < 4'd2 |=> host_rdata[15:4] == 12'h000);

    p_word_step_r7: assert property (@(posedge clk) disable iff (rst)
        win_acc && host_word |=> ptr_q == AW'($past(ptr_q) + AW'(2)));

    p_byte_step_r8: assert property (@(posedge clk) disable iff (rst)
        win_acc && !host_word && !ptr_q[0] |=> ptr_q == AW'($past(ptr_q) + AW'(1)));

    p_odd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        win_acc && !host_word && ptr_q[0] |=> $stable(ptr_q));

    p_odd_zero_r9: assert property (@(posedge clk) disable iff (rst)
        win_acc && host_rd && !host_word && ptr_q[0] |=> host_rdata == 16'h0000);

    p_oob_zero_r10: assert property (@(posedge clk) disable iff (rst)
        host_rd && host_port && idx_q > 4'd9 |=> host_rdata == 16'h0000);

endmodule

bind idxcfg_port idxcfg_port_chk #(
    .SRAM_BYTES(SRAM_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pio_mode  (pio_mode),
    .host_port (host_port),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_word (host_word),
    .host_rdata(host_rdata),
    .idx_q     (idx_q),
    .ptr_q     (sram_ptr)
);

// File: tb/idxcfg_port_tb.sv
module idxcfg_port_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pio_mode = 1'b0;
    logic        host_port = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_word = 1'b1;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    idxcfg_port #(.SRAM_BYTES(256)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .pio_mode  (pio_mode),
        .host_port (host_port),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .host_word (host_word),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    // Monitor: a read strobe seen at an edge yields data by the next negedge.
    initial begin
        forever begin
            @(posedge clk);
            if (host_rd && !rst) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL scoreboard empty: got %h expected none", host_rdata);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    n_checks++;
                    if (host_rdata !== e) begin
                        n_fail++;
                        $display("FAIL %s: got %h expected %h", t, host_rdata, e);
                    end
                end
            end
        end
    end

    task automatic wr_port(input logic port, input logic [15:0] d, input logic word);
        @(negedge clk);
        host_port = port; host_wdata = d; host_word = word; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_port(input logic port, input logic word, input logic [15:0] e, input string t);
        @(negedge clk);
        host_port = port; host_word = word; host_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_idx(input int i);
        wr_port(1'b0, 16'(i), 1'b1);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv [10];
        rv = '{16'h0005, 16'h0005, 16'h0002, 16'h8000, 16'h0000,
               16'h0084, 16'h0008, 16'h0090, 16'h0000, 16'h0000};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: index resets to zero
        rd_port(1'b0, 1'b1, 16'h0000, "R1 index reset");
        // R2: reset values
        for (int i = 0; i < 10; i++) begin
            set_idx(i);
            rd_port(1'b1, 1'b1, rv[i], $sformatf("R2 reset value idx %0d", i));
        end
        // R3: full registers
        set_idx(2); wr_port(1'b1, 16'hBEEF, 1'b1);
        rd_port(1'b1, 1'b1, 16'hBEEF, "R3 reg2 readback");
        set_idx(9); wr_port(1'b1, 16'h1234, 1'b1);
        rd_port(1'b1, 1'b1, 16'h1234, "R3 reg9 readback");
        set_idx(5); wr_port(1'b1, 16'h0000, 1'b0);
        rd_port(1'b1, 1'b1, 16'h0000, "R3 reg5 cleared");
        // R4: read-only
        set_idx(8); wr_port(1'b1, 16'hFFFF, 1'b1);
        rd_port(1'b1, 1'b1, 16'h0000, "R4 reg8 read-only");
        // R5: strobe fields
        set_idx(0); wr_port(1'b1, 16'hFFFA, 1'b1);
        rd_port(1'b1, 1'b1, 16'h000A, "R5 reg0 masked");
        set_idx(1); wr_port(1'b1, 16'h7003, 1'b1);
        rd_port(1'b1, 1'b1, 16'h0003, "R5 reg1 masked");
        // R10: out of range
        set_idx(12); wr_port(1'b1, 16'hAAAA, 1'b1);
        rd_port(1'b1, 1'b1, 16'h0000, "R10 idx 12 zero");
        set_idx(15); wr_port(1'b1, 16'h5555, 1'b1);
        rd_port(1'b1, 1'b1, 16'h0000, "R10 idx 15 zero");
        // R1: index keeps low 4 bits
        wr_port(1'b0, 16'h0037, 1'b1);
        rd_port(1'b0, 1'b1, 16'h0007, "R1 index low bits");

        // Programmed-I/O mode
        @(negedge clk); pio_mode = 1'b1;
        set_idx(1);
        rd_port(1'b1, 1'b1, 16'h0000, "R6 pointer reset");
        wr_port(1'b1, 16'h0012, 1'b1);
        set_idx(0);
        wr_port(1'b1, 16'h3344, 1'b1);
        set_idx(1);
        rd_port(1'b1, 1'b1, 16'h0014, "R7 word write step 2");
        wr_port(1'b1, 16'h0012, 1'b1);
        set_idx(0);
        wr_port(1'b1, 16'h5577, 1'b0);
        set_idx(1);
        rd_port(1'b1, 1'b1, 16'h0013, "R8 byte write step 1");
        set_idx(0);
        wr_port(1'b1, 16'h0099, 1'b0);
        rd_port(1'b1, 1'b0, 16'h0000, "R9 odd byte read zero");
        set_idx(1);
        rd_port(1'b1, 1'b1, 16'h0013, "R9 pointer held");
        wr_port(1'b1, 16'h0012, 1'b1);
        set_idx(0);
        rd_port(1'b1, 1'b1, 16'h3377, "R9 SRAM unchanged, R7 little-endian read");
        set_idx(1);
        rd_port(1'b1, 1'b1, 16'h0014, "R7 word read step 2");
        wr_port(1'b1, 16'h0012, 1'b1);
        set_idx(0);
        rd_port(1'b1, 1'b0, 16'h0077, "R8 byte read");
        set_idx(1);
        rd_port(1'b1, 1'b1, 16'h0013, "R8 byte read step 1");
        // R6/R7: wrap at the top of the SRAM
        wr_port(1'b1, 16'h00FF, 1'b1);
        set_idx(0);
        wr_port(1'b1, 16'hC0DE, 1'b1);
        set_idx(1);
        rd_port(1'b1, 1'b1, 16'h0001, "R6 pointer wrap");
        wr_port(1'b1, 16'h0000, 1'b1);
        set_idx(0);
        rd_port(1'b1, 1'b0, 16'h00C0, "R7 wrapped high byte");
        set_idx(1);
        wr_port(1'b1, 16'hAB40, 1'b1);
        rd_port(1'b1, 1'b1, 16'h0040, "R6 pointer width");

        // R11: strobe fields retained
        @(negedge clk); pio_mode = 1'b0;
        set_idx(0);
        rd_port(1'b1, 1'b1, 16'h000A, "R11 reg0 retained");
        set_idx(1);
        rd_port(1'b1, 1'b1, 16'h0003, "R11 reg1 retained");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard drain: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule